// File: doc/BRIEF.md
# Latched Seven-Segment Decoder with Cascadable Zero Blanking

This block sits between a four-decade BCD counter and a static seven-segment display. It holds a snapshot of the four counter digits and the counter's overflow (half-digit) flag in output registers. An active-low store input controls when the snapshot is taken. Each held digit is decoded to its own seven segment lines, and one extra line drives the half-digit segment. No line is multiplexed.

Leading zeros are suppressed from the most significant digit downward while the blanking-enable input is high and the held half-digit flag is clear. A blanking-status output goes high when every digit of the group is dark. Several groups can be chained by feeding each group's status output into the enable input of the next lower-order group, so that zero suppression runs across all of their digits.

Top module: `lzbSegLatch`

## Requirements
- R1: On each rising clock edge with `storeN` low, the held digits and half-digit flag take the values on `digitsIn` and `halfIn`. The outputs show them from that edge on. `digitsIn[3:0]` is the least significant digit.
- R2: On a rising clock edge with `storeN` high, the held values do not change, whatever `digitsIn` and `halfIn` do.
- R3: A held code 0..9 lights the segments of the usual decimal glyph. Digit i is output on `segOut[7*i +: 7]`, with bit 0 = a, bit 1 = b, and so on up to bit 6 = g, and 1 = segment on. In hex, the codes 0..9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R4: A held code from 10 to 15 gives all seven segments off. For zero suppression, such a code counts as a nonzero digit.
- R5: With blanking allowed, digits are darkened from the most significant one downward. This stops at the first digit whose code is not zero, and every digit from there down is shown. If all four codes are zero, all four digits are dark.
- R6: With `blankEnIn` low, no digit is darkened and `blankOut` is low. `blankEnIn` acts on the outputs in the same cycle, without a clock edge.
- R7: While the held half-digit flag is set, no digit is darkened and `blankOut` is low.
- R8: `blankOut` is high exactly when `blankEnIn` is high, the held half-digit flag is clear, and all four held codes are zero.
- R9: `halfSegOut` is high exactly when the held half-digit flag is set.
- R10: While `rst_n` is low, the held digits and flag are zero. With `blankEnIn` high, the display is then fully dark and `blankOut` is high.
- R11: When a higher-order group's `blankOut` drives a lower-order group's `blankEnIn`, the lower group suppresses its leading zeros only while the higher group is fully dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the held values |
| digitsIn | input | 16 | Four BCD digits from the counter, LSD in bits 3:0 |
| halfIn | input | 1 | Counter overflow / half-digit flag |
| storeN | input | 1 | Active-low load enable for the held values |
| blankEnIn | input | 1 | Zero-suppression enable (from the higher-order group) |
| segOut | output | 28 | Seven segment lines per digit, a..g in bits 0..6 |
| halfSegOut | output | 1 | Half-digit segment line |
| blankOut | output | 1 | High when all four digits are dark |

## Verification
A snapshot load and a change in the blanking decision can land in the same cycle. Loading a new half-digit flag or new digit values changes both the glyphs and the zero-suppression extent at that same clock edge. A toggle of `blankEnIn` adds a further change without any edge. The sweep provokes this by loading every 16-bit digit pattern back to back. The half flag and the enable are varied with the pattern index, so zero groups are often loaded together with a flag flip. Each pattern is judged one clock later against leading-zero counts computed arithmetically. A hold phase changes `blankEnIn` while `storeN` is high, to show that blanking follows at once while the held digits stay frozen.

// File: rtl/lzbSegPkg.sv
package lzbSegPkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;

  typedef struct packed {
    logic latchLoad;   // take a new snapshot this edge
    logic blankAllow;  // zero suppression permitted
  } lzbStrobes_t;
endpackage

// File: rtl/lzbSegCtrl.sv
module lzbSegCtrl
  import lzbSegPkg::*;
(
  input  logic        storeN,
  input  logic        blankEnIn,
  input  logic        halfHeld,
  output lzbStrobes_t strobes
);
  always_comb begin
    strobes.latchLoad  = ~storeN;
    strobes.blankAllow = blankEnIn & ~halfHeld;
  end
endmodule

// File: rtl/lzbSegDecoder.sv
module lzbSegDecoder
  import lzbSegPkg::*;
(
  input  logic [DIGIT_W-1:0] code,
  input  logic               dark,
  output logic [SEG_W-1:0]   seg
);
  logic [SEG_W-1:0] glyph;

  always_comb begin
    unique case (code)
      4'd0:    glyph = 7'b0111111;
      4'd1:    glyph = 7'b0000110;
      4'd2:    glyph = 7'b1011011;
      4'd3:    glyph = 7'b1001111;
      4'd4:    glyph = 7'b1100110;
      4'd5:    glyph = 7'b1101101;
      4'd6:    glyph = 7'b1111101;
      4'd7:    glyph = 7'b0000111;
      4'd8:    glyph = 7'b1111111;
      4'd9:    glyph = 7'b1101111;
      default: glyph = '0;
    endcase
    seg = dark ? '0 : glyph;
  end
endmodule

// File: rtl/lzbSegDatapath.sv
module lzbSegDatapath
  import lzbSegPkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  lzbStrobes_t                   strobes,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] digitsIn,
  input  logic                          halfIn,
  output logic [NUM_DIGITS*SEG_W-1:0]   segOut,
  output logic                          halfHeld,
  output logic                          allDark
);
  localparam int BUS_W = NUM_DIGITS * DIGIT_W;

  logic [BUS_W-1:0]    digitsHeld;
  logic [NUM_DIGITS:0] zeroRun;   // zeroRun[i]: suppression still active at digit i

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digitsHeld <= '0;
      halfHeld   <= 1'b0;
    end else if (strobes.latchLoad) begin
      digitsHeld <= digitsIn;
      halfHeld   <= halfIn;
    end
  end

  assign zeroRun[NUM_DIGITS] = strobes.blankAllow;

  for (genvar i = NUM_DIGITS - 1; i >= 0; i--) begin : g_digit
    logic [DIGIT_W-1:0] code;
    assign code       = digitsHeld[i*DIGIT_W +: DIGIT_W];
    assign zeroRun[i] = zeroRun[i+1] & (code == '0);

    lzbSegDecoder u_dec (
      .code (code),
      .dark (zeroRun[i]),
      .seg  (segOut[i*SEG_W +: SEG_W])
    );
  end

  assign allDark = zeroRun[0];
endmodule

// File: rtl/lzbSegLatch.sv
module lzbSegLatch
  import lzbSegPkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] digitsIn,
  input  logic        halfIn,
  input  logic        storeN,
  input  logic        blankEnIn,
  output logic [27:0] segOut,
  output logic        halfSegOut,
  output logic        blankOut
);
  lzbStrobes_t strobes;
  logic        halfHeld;
  logic        allDark;

  lzbSegCtrl u_ctrl (
    .storeN    (storeN),
    .blankEnIn (blankEnIn),
    .halfHeld  (halfHeld),
    .strobes   (strobes)
  );

  lzbSegDatapath #(.NUM_DIGITS(4)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .digitsIn (digitsIn),
    .halfIn   (halfIn),
    .segOut   (segOut),
    .halfHeld (halfHeld),
    .allDark  (allDark)
  );

  assign halfSegOut = halfHeld;
  assign blankOut   = allDark;
endmodule

// File: rtl/lzbSegLatchChk.sv
module lzbSegLatchChk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] digitsIn,
  input logic        halfIn,
  input logic        storeN,
  input logic        blankEnIn,
  input logic [27:0] segOut,
  input logic        halfSegOut,
  input logic        blankOut
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && storeN) |=> ((blankEnIn != $past(blankEnIn)) ||
                           ($stable(segOut) && $stable(halfSegOut) && $stable(blankOut))));

  // R9
  half_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !storeN) |=> (halfSegOut == $past(halfIn)));

  // R8
  dark_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blankOut |-> (segOut == '0 && !halfSegOut && blankEnIn));

  // R6
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blankEnIn |-> !blankOut);

  // R7
  half_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halfSegOut |-> !blankOut);

  // R1
  load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !storeN && digitsIn == '0 && !halfIn) |=>
      (blankOut == blankEnIn));
endmodule

bind lzbSegLatch lzbSegLatchChk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .digitsIn   (digitsIn),
  .halfIn     (halfIn),
  .storeN     (storeN),
  .blankEnIn  (blankEnIn),
  .segOut     (segOut),
  .halfSegOut (halfSegOut),
  .blankOut   (blankOut)
);

// File: tb/lzbSegLatch_tb.sv
module lzbSegLatch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] digitsIn = '0;
  logic        halfIn = 1'b0;
  logic        storeN = 1'b1;
  logic        blankEnIn = 1'b1;
  logic [27:0] segOut;
  logic        halfSegOut;
  logic        blankOut;

  logic [15:0] lowDigits = 16'h0050;
  logic [27:0] lowSeg;
  logic        lowHalf;
  logic        lowBlank;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lzbSegLatch u_dut (
    .clk(clk), .rst_n(rst_n), .digitsIn(digitsIn), .halfIn(halfIn),
    .storeN(storeN), .blankEnIn(blankEnIn), .segOut(segOut),
    .halfSegOut(halfSegOut), .blankOut(blankOut)
  );

  lzbSegLatch u_low (
    .clk(clk), .rst_n(rst_n), .digitsIn(lowDigits), .halfIn(1'b0),
    .storeN(storeN), .blankEnIn(blankOut), .segOut(lowSeg),
    .halfSegOut(lowHalf), .blankOut(lowBlank)
  );

  function automatic logic [6:0] glyphOf(int v);
    case (v)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  // expected outputs {segs, half, dark} from held digits, flag and enable
  function automatic logic [29:0] model(logic [15:0] d, logic h, logic be);
    logic [27:0] s;
    int lead = 0;
    logic allow = be && !h;
    for (int p = 3; p >= 0; p--) begin
      if (d[p*4 +: 4] != 0) break;
      lead++;
    end
    for (int i = 0; i < 4; i++) begin
      if (allow && (3 - i) < lead) s[i*7 +: 7] = '0;
      else s[i*7 +: 7] = glyphOf(int'(d[i*4 +: 4]));
    end
    return {s, h, allow && lead == 4};
  endfunction

  task automatic check(string req, logic [29:0] act, logic [29:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string reqFor(logic [15:0] d, logic h, logic be);
    for (int i = 0; i < 4; i++) if (d[i*4 +: 4] > 9) return "R4";
    if (!be) return "R6";
    if (h) return "R7";
    if (d == 0) return "R8";
    return "R5";
  endfunction

  task automatic loadAndCheck(logic [15:0] d, logic h, logic be);
    digitsIn = d; halfIn = h; blankEnIn = be; storeN = 1'b0;
    @(negedge clk);
    check(reqFor(d, h, be), {segOut, halfSegOut, blankOut}, model(d, h, be));
  endtask

  initial begin
    #(190000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state, fully dark
    check("R10", {segOut, halfSegOut, blankOut}, {28'h0, 1'b0, 1'b1});
    digitsIn = 16'h1234; storeN = 1'b0;
    @(negedge clk);
    check("R10", {segOut, halfSegOut, blankOut}, {28'h0, 1'b0, 1'b1});
    rst_n = 1'b1;
    storeN = 1'b1;
    @(negedge clk);
    check("R10", {segOut, halfSegOut, blankOut}, {28'h0, 1'b0, 1'b1});

    // R1 R3: decimal glyphs on each position
    loadAndCheck(16'h0123, 1'b0, 1'b0);
    loadAndCheck(16'h4567, 1'b0, 1'b1);
    loadAndCheck(16'h8901, 1'b1, 1'b1);
    loadAndCheck(16'h9876, 1'b0, 1'b1);

    // R2: hold while storeN high
    loadAndCheck(16'h0042, 1'b0, 1'b1);
    storeN = 1'b1; digitsIn = 16'h5678; halfIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R2", {segOut, halfSegOut, blankOut}, model(16'h0042, 1'b0, 1'b1));
    // R6: enable drop takes effect without an edge
    blankEnIn = 1'b0; #1;
    check("R6", {segOut, halfSegOut, blankOut}, model(16'h0042, 1'b0, 1'b0));
    @(negedge clk);
    check("R2", {segOut, halfSegOut, blankOut}, model(16'h0042, 1'b0, 1'b0));

    // R7 R9: flag blocks blanking, lights half segment
    loadAndCheck(16'h0000, 1'b1, 1'b1);
    loadAndCheck(16'h0000, 1'b0, 1'b1);
    loadAndCheck(16'h00A0, 1'b0, 1'b1);

    // R11: cascade into lower group holding 0050
    loadAndCheck(16'h0000, 1'b0, 1'b1);
    check("R11", {lowSeg, lowBlank}, {7'h00, 7'h00, 7'h6D, 7'h3F, 1'b0});
    loadAndCheck(16'h0001, 1'b0, 1'b1);
    check("R11", {lowSeg, lowBlank}, {7'h3F, 7'h3F, 7'h6D, 7'h3F, 1'b0});
    loadAndCheck(16'h0000, 1'b1, 1'b1);
    check("R11", {lowSeg, lowBlank}, {7'h3F, 7'h3F, 7'h6D, 7'h3F, 1'b0});
    lowDigits = 16'h0000;
    loadAndCheck(16'h0000, 1'b0, 1'b1);
    check("R11", {lowSeg, lowBlank}, {28'h0, 1'b1});

    // R5 R3: every decimal count, blanking on
    for (int n = 0; n < 10000; n++) begin
      logic [15:0] b;
      b = {4'(n / 1000), 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
      loadAndCheck(b, 1'b0, 1'b1);
    end

    // R4 R5 R6 R7 R8 R9: all codes with varied flag and enable
    for (int v = 0; v < 65536; v++) begin
      loadAndCheck(16'(v), (v % 7) == 0, (v % 5) != 0);
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule